// File: doc/BRIEF.md
# Oversampled UART Receiver with Voting

This block recovers asynchronous serial characters from a raw receive line. It runs on the system clock. A tick enable, asserted once every sixteenth of a bit period, paces all of its work. The raw line first passes through a two-stage synchronizer. A counter then tracks the tick position inside each bit. The receiver takes three samples around the middle of every bit and decides the bit from them. A falling edge alone never starts a frame: the line must stay low through the whole middle of the start bit, so short spikes are rejected.

Each character is one start bit, eight data bits with the least significant bit first, and one stop bit. Once the stop bit is decided, the byte and a framing-error flag are presented together with a strobe that lasts one clock. They stay unchanged until the next character completes. After a bad stop bit the receiver stays parked until the line goes high again. This prevents a held-low line from being read as a stream of zero bytes.

Top module: `rxo_receiver`

## Requirements
- R1: Reset is synchronous and active high. It clears the byte output, the strobe and the error flag. The line passes through a two-flop synchronizer preset to the idle-high level, so a line held high after reset produces no character.
- R2: While idle, the tick counter advances only on ticks where the synchronized line is low, and it clears on any tick where the line is high. A start is accepted only after ten consecutive low ticks (positions 0 to 9, which cover the middle samples 7, 8 and 9). A low pulse of nine ticks or fewer yields nothing, and the next proper character is still received.
- R3: The data bits are assembled least significant bit first. Each bit is decided at position 9 of its own 16-tick window, and each window starts 16 ticks after the previous one. Every byte value from 0x00 to 0xFF is received unchanged.
- R4: Each bit is the majority of the samples at positions 7, 8 and 9. One disagreeing sample leaves the bit unchanged, and two disagreeing samples invert it.
- R5: A character is still recovered exactly when the sender makes one bit in every three a tick shorter, or a tick longer, than nominal.
- R6: The stop bit is decided by the same vote. If it votes high, the error flag is 0. If it votes low, the flag is 1. In both cases the byte and the strobe are delivered.
- R7: After a low stop bit, no new start is accepted until a tick sees the line high, however long the line stays low.
- R8: The strobe is high for exactly one clock per character. The byte and the error flag change only together with the strobe and hold their values in between.
- R9: State changes only on clocks where the tick enable is high. Line activity without ticks has no effect, and a character paused in the middle by withheld ticks is still received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Oversampling enable, 16 per bit period |
| rx_i | input | 1 | Raw asynchronous receive line |
| data_o | output | DATA_W | Last received byte |
| valid_o | output | 1 | One-clock strobe when a character completes |
| ferr_o | output | 1 | Stop bit voted low for the last character |

## Verification
The checker watches several rules on every clock: the synchronizer latency, that a high line keeps the receiver idle, the parked state after a framing error, the one-clock strobe, the holding of the byte and the flag between characters, and the freezing of state without ticks. The bench scenarios cover what no single-cycle property can show. These are the value of every possible byte, the outcome of the vote under one or two corrupted samples, the tolerance to sender rate drift, the boundary between a nine-tick and a ten-tick start pulse, and the correct resumption of a character after a long stall of the tick enable.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

    // default oversampling ratio and character width
    localparam int unsigned OVS_DEF  = 16;
    localparam int unsigned WORD_DEF = 8;
    // number of samples voted per bit
    localparam int unsigned VOTE_N   = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_STOP,
        ST_WAIT_HIGH
    } rx_state_e;

    // decision produced by the bit timer once per bit window
    typedef struct packed {
        logic strobe;    // decision tick (last middle sample)
        logic bit_val;   // majority of the middle samples
        logic all_low;   // every middle sample was low
    } vote_t;

    function automatic logic majority(input logic [VOTE_N-1:0] s);
        return ($countones(s) > (VOTE_N / 2));
    endfunction

endpackage

// File: rtl/rxo_sync.sv
module rxo_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= RST_VAL;
                else       chain_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= {STAGES{RST_VAL}};
                else       chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rxo_bit_timer.sv
module rxo_bit_timer
    import rxo_pkg::*;
#(
    parameter int unsigned OVS   = OVS_DEF,
    parameter int unsigned FIRST = 7,
    parameter int unsigned LAST  = 9
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  tick_i,
    input  logic  line_i,
    input  logic  restart_i,  // hold position at zero, take no samples
    input  logic  clear_i,    // end of character: back to position zero
    output vote_t vote_o
);

    localparam int unsigned CNT_W = (OVS > 1) ? $clog2(OVS) : 1;

    logic [CNT_W-1:0]  pos_q;
    logic [VOTE_N-2:0] smp_q;
    logic [VOTE_N-1:0] votes;
    logic              in_window;

    assign in_window = (pos_q >= CNT_W'(FIRST)) && (pos_q < CNT_W'(LAST));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos_q <= '0;
            smp_q <= '0;
        end else if (tick_i) begin
            if (restart_i || clear_i)
                pos_q <= '0;
            else if (pos_q == CNT_W'(OVS - 1))
                pos_q <= '0;
            else
                pos_q <= pos_q + 1'b1;

            if (!restart_i && in_window)
                smp_q <= {smp_q[VOTE_N-3:0], line_i};
        end
    end

    always_comb begin
        votes          = {smp_q, line_i};
        vote_o.strobe  = tick_i && !restart_i && (pos_q == CNT_W'(LAST));
        vote_o.bit_val = majority(votes);
        vote_o.all_low = (votes == '0);
    end

endmodule

// File: rtl/rxo_frame_fsm.sv
module rxo_frame_fsm
    import rxo_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              line_i,
    input  vote_t             vote_i,
    output rx_state_e         state_o,
    output logic              clear_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              ferr_o
);

    localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e         state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              ferr_q;

    assign clear_o = (state_q == ST_STOP) && vote_i.strobe;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            shift_q <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (vote_i.strobe && vote_i.all_low) begin
                        state_q <= ST_DATA;
                        idx_q   <= '0;
                    end
                end
                ST_DATA: begin
                    if (vote_i.strobe) begin
                        shift_q <= {vote_i.bit_val, shift_q[DATA_W-1:1]};
                        if (idx_q == IDX_W'(DATA_W - 1))
                            state_q <= ST_STOP;
                        else
                            idx_q <= idx_q + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (vote_i.strobe) begin
                        data_q  <= shift_q;
                        ferr_q  <= !vote_i.bit_val;
                        valid_q <= 1'b1;
                        state_q <= vote_i.bit_val ? ST_IDLE : ST_WAIT_HIGH;
                    end
                end
                ST_WAIT_HIGH: begin
                    if (tick_i && line_i)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign data_o  = data_q;
    assign valid_o = valid_q;
    assign ferr_o  = ferr_q;

endmodule

// File: rtl/rxo_receiver.sv
module rxo_receiver
    import rxo_pkg::*;
#(
    parameter int unsigned OVS         = OVS_DEF,
    parameter int unsigned DATA_W      = WORD_DEF,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              rx_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              ferr_o
);

    // middle samples sit symmetrically around the bit centre
    localparam int unsigned MID   = OVS / 2;
    localparam int unsigned FIRST = MID - (VOTE_N / 2);
    localparam int unsigned LAST  = MID + (VOTE_N / 2);

    logic      line_s;
    logic      restart_s;
    logic      clear_s;
    vote_t     vote_s;
    rx_state_e state_s;

    rxo_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (rx_i),
        .q_o   (line_s)
    );

    // idle counts only while low; parked state waits for a high line
    assign restart_s = ((state_s == ST_IDLE) && line_s) || (state_s == ST_WAIT_HIGH);

    rxo_bit_timer #(
        .OVS   (OVS),
        .FIRST (FIRST),
        .LAST  (LAST)
    ) i_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick_i),
        .line_i    (line_s),
        .restart_i (restart_s),
        .clear_i   (clear_s),
        .vote_o    (vote_s)
    );

    rxo_frame_fsm #(
        .DATA_W (DATA_W)
    ) i_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (tick_i),
        .line_i  (line_s),
        .vote_i  (vote_s),
        .state_o (state_s),
        .clear_o (clear_s),
        .data_o  (data_o),
        .valid_o (valid_o),
        .ferr_o  (ferr_o)
    );

endmodule

// File: rtl/rxo_checker.sv
module rxo_checker
    import rxo_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_DEF
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              tick_i,
    input logic              rx_i,
    input logic              line_i,
    input rx_state_e         state_i,
    input logic [DATA_W-1:0] data_i,
    input logic              valid_i,
    input logic              ferr_i
);

    // written for the default two-stage synchronizer
    AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(rst_i, 2)) |-> (line_i == $past(rx_i, 2))); // R1

    AST_HIGH_KEEPS_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_IDLE && tick_i && line_i) |=> (state_i == ST_IDLE)); // R2

    AST_FERR_PARKS: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && ferr_i) |-> (state_i == ST_WAIT_HIGH)); // R7

    AST_PARK_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_WAIT_HIGH && !(tick_i && line_i)) |=> (state_i == ST_WAIT_HIGH)); // R7

    AST_STROBE_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |=> !valid_i); // R8

    AST_OUTPUT_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |-> ($stable(data_i) && $stable(ferr_i))); // R8

    AST_NO_TICK_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> $stable(state_i)); // R9

    AST_STROBE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |-> $past(tick_i)); // R9

endmodule

bind rxo_receiver rxo_checker #(
    .DATA_W (DATA_W)
) i_rxo_checker (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tick_i  (tick_i),
    .rx_i    (rx_i),
    .line_i  (line_s),
    .state_i (state_s),
    .data_i  (data_o),
    .valid_i (valid_o),
    .ferr_i  (ferr_o)
);

// File: tb/test_rxo_receiver.sv
`timescale 1ns/1ps
module test_rxo_receiver;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic [7:0] data_o;
    logic       valid_o;
    logic       ferr_o;

    int  n_checks = 0;
    int  n_errs = 0;
    int  nvalid = 0;
    int  pulse_bad = 0;
    logic prev_v = 1'b0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    rxo_receiver i_rxo_receiver (
        .clk_i   (clk),
        .rst_i   (rst),
        .tick_i  (tick),
        .rx_i    (rx),
        .data_o  (data_o),
        .valid_o (valid_o),
        .ferr_o  (ferr_o)
    );

    // strobe monitor: counts characters and strobes longer than one clock
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            nvalid++;
            if (prev_v) pulse_bad++;
        end
        prev_v = valid_o;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one oversampling slot: three clocks, tick on the last, so the
    // synchronized line shows this slot's value at its own tick
    task automatic slot(input logic v, input bit ten);
        rx = v;
        tick = 1'b0;
        repeat (2) @(negedge clk);
        tick = ten;
        @(negedge clk);
        tick = 1'b0;
    endtask

    function automatic int bit_len(input int j, input int drift);
        if (drift > 0) return (j % 3 == 2) ? 15 : 16;
        if (drift < 0) return (j % 3 == 2) ? 17 : 16;
        return 16;
    endfunction

    // mode 0 clean, 1 corrupt sample 8 of each data bit, 2 corrupt samples 7 and 8
    task automatic send_frame(input logic [7:0] b, input logic stop_v, input int mode,
                              input int drift, input int gap, input int pause_at,
                              input bit ten);
        int k = 0;
        for (int j = 0; j < 10; j++) begin
            logic bv;
            bv = (j == 0) ? 1'b0 : (j == 9) ? stop_v : b[j-1];
            for (int s = 0; s < bit_len(j, drift); s++) begin
                logic v;
                v = bv;
                if (j >= 1 && j <= 8) begin
                    if (mode == 1 && s == 8) v = ~bv;
                    if (mode == 2 && (s == 7 || s == 8)) v = ~bv;
                end
                if (k == pause_at)
                    for (int p = 0; p < 50; p++) slot((p % 3) == 0, 1'b0);
                slot(v, ten);
                k++;
            end
        end
        for (int g = 0; g < gap; g++) slot(1'b1, ten);
    endtask

    task automatic frame_check(input int base, input logic [7:0] ed, input logic ef,
                               input string tag);
        check(nvalid == base + 1, tag, "strobe count", nvalid - base, 1);
        check(data_o == ed, tag, "data", data_o, ed);
        check(ferr_o == ef, tag, "framing flag", ferr_o, ef);
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(valid_o == 1'b0, "R1", "strobe after reset", valid_o, 0);
        check(data_o == 8'h00, "R1", "data after reset", data_o, 0);
        check(ferr_o == 1'b0, "R1", "flag after reset", ferr_o, 0);
        for (int i = 0; i < 30; i++) slot(1'b1, 1'b1);
        check(nvalid == 0, "R1", "idle-high characters", nvalid, 0);

        // R3 every byte value, clean line
        for (int b = 0; b < 256; b++) begin
            base = nvalid;
            send_frame(8'(b), 1'b1, 0, 0, 2, -1, 1'b1);
            frame_check(base, 8'(b), 1'b0, "R3");
        end

        // R4 majority vote: one bad sample ignored, two bad samples win
        for (int b = 0; b < 256; b += 9) begin
            base = nvalid;
            send_frame(8'(b), 1'b1, 1, 0, 3, -1, 1'b1);
            frame_check(base, 8'(b), 1'b0, "R4");
        end
        for (int b = 0; b < 256; b += 13) begin
            base = nvalid;
            send_frame(8'(b), 1'b1, 2, 0, 3, -1, 1'b1);
            frame_check(base, ~8'(b), 1'b0, "R4");
        end

        // R5 sender rate drift in both directions
        for (int i = 0; i < 6; i++) begin
            base = nvalid;
            send_frame(8'(i * 41 + 7), 1'b1, 0, 1, 3, -1, 1'b1);
            frame_check(base, 8'(i * 41 + 7), 1'b0, "R5");
            base = nvalid;
            send_frame(8'(i * 73 + 5), 1'b1, 0, -1, 3, -1, 1'b1);
            frame_check(base, 8'(i * 73 + 5), 1'b0, "R5");
        end

        // R2 low pulses of 1..9 ticks are rejected
        for (int k = 1; k <= 9; k++) begin
            base = nvalid;
            for (int i = 0; i < k; i++) slot(1'b0, 1'b1);
            for (int i = 0; i < 30; i++) slot(1'b1, 1'b1);
            check(nvalid == base, "R2", "short low pulse", nvalid - base, 0);
        end
        // R2 ten low ticks start a character of all ones
        base = nvalid;
        for (int i = 0; i < 10; i++) slot(1'b0, 1'b1);
        for (int i = 0; i < 150; i++) slot(1'b1, 1'b1);
        frame_check(base, 8'hFF, 1'b0, "R2");
        // R2 glitch right before a real character
        base = nvalid;
        for (int i = 0; i < 6; i++) slot(1'b0, 1'b1);
        slot(1'b1, 1'b1);
        send_frame(8'h5A, 1'b1, 0, 0, 3, -1, 1'b1);
        frame_check(base, 8'h5A, 1'b0, "R2");

        // R6 low stop bit, then R7 a long low line stays parked
        base = nvalid;
        send_frame(8'hC3, 1'b0, 0, 0, 0, -1, 1'b1);
        for (int i = 0; i < 40; i++) slot(1'b0, 1'b1);
        frame_check(base, 8'hC3, 1'b1, "R6");
        check(nvalid == base + 1, "R7", "characters while parked", nvalid - base, 1);
        check(data_o == 8'hC3 && ferr_o == 1'b1, "R8", "outputs held",
              {ferr_o, data_o}, 9'h1C3);
        for (int i = 0; i < 3; i++) slot(1'b1, 1'b1);
        base = nvalid;
        send_frame(8'h3C, 1'b1, 0, 0, 3, -1, 1'b1);
        frame_check(base, 8'h3C, 1'b0, "R6");
        check(pulse_bad == 0, "R8", "strobes longer than one clock", pulse_bad, 0);

        // R9 a full character with no ticks has no effect
        base = nvalid;
        send_frame(8'h96, 1'b1, 0, 0, 3, -1, 1'b0);
        check(nvalid == base, "R9", "characters without ticks", nvalid - base, 0);
        check(data_o == 8'h3C, "R9", "data without ticks", data_o, 8'h3C);
        // R9 character stalled in the middle
        base = nvalid;
        send_frame(8'h96, 1'b1, 0, 0, 3, 70, 1'b1);
        frame_check(base, 8'h96, 1'b0, "R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (196000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: run incomplete, actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

endmodule